// File: doc/BRIEF.md
# Masked Register Page Loader

This block takes the byte stream of one register-settings frame (an offset into a 512-byte page, a data byte and a valid strobe) and applies it to a register file. The register file is split into eight banks: the font control, the artifact control, the extras control, the enhanced-mode control, a semigraphics palette, an artifact palette, an extra palette and a set of display timing fields. A read port returns the current value at any page offset one cycle later.

The first two bytes of a frame steer the rest. Offset 0 is a reset vector: each set bit returns one bank to its built-in defaults at once. Offset 1 is an edit mask: a later byte is stored only when the mask bit of the bank that owns its offset is set. A `frame_start` strobe opens each frame and clears the mask. As a result, a frame that never delivers offset 1 changes nothing except what its reset byte restores.

Top module: `page_loader_top`

## Requirements
- R1: After `rst`, every bank holds its defaults. The defaults are: font (offset 3) 0x00; artifact (offset 4) 0x0D; extras (offset 5) 0x40; enhanced modes (offset 8) 0x00; all palette bytes 0x00. The timing bytes at offsets 480..490 are 02,80,10,60,30,00,01,E0,0A,02,21 (hex). The edit mask reads 0x00.
- R2: A valid byte at offset 0 restores every bank whose bit is set, and only those banks, one cycle later. The bit order is: bit0 font, bit1 artifact, bit2 extras, bit3 semigraphics palette, bit4 artifact palette, bit5 extra palette, bit6 timing, bit7 enhanced modes.
- R3: A valid byte at offset 1 becomes the edit mask, using the same bit order as R2. Reading offset 1 returns the current mask.
- R4: A valid byte at a bank offset whose mask bit is set is stored there. The bank offsets are: 3 font, 4 artifact, 5 extras, 8 enhanced modes, 32..53 semigraphics palette, 64..127 artifact palette, 128..135 extra palette, and 480..490 except 485 for timing.
- R5: A valid byte at a bank offset whose mask bit is clear leaves that offset unchanged.
- R6: Offsets outside the bank ranges of R4, other than 1, ignore writes and read 0x00. These include offsets 2, 6, 7, 9..31, 54..63, 136..479, 485 and 491..511, as well as offset 0.
- R7: `frame_start` clears the edit mask. A write in the same cycle as `frame_start` is judged against the cleared mask, except a write to offset 1, which loads the mask.
- R8: A reset byte takes effect before any later byte of the same frame, so a bank that is both reset and edited ends with the newly written values.
- R9: `rd_data` is registered. It shows the value at the `rd_offset` presented before the previous rising edge, and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Opens a register frame and clears the edit mask |
| wr_valid | input | 1 | A frame byte is present this cycle |
| wr_offset | input | 9 | Page offset of the frame byte |
| wr_data | input | 8 | Frame byte value |
| rd_offset | input | 9 | Page offset to read |
| rd_data | output | 8 | Value at the offset read, one cycle later |

## Verification
The hardest cases to reach are the ones where frame control and data collide. One is a byte arriving in the same cycle as `frame_start` while the old mask still allows its bank. Another is a reset byte followed by edits to the same bank within one frame. The bench builds both cases directly: it loads a permissive mask, then pulses `frame_start` together with a write. In a separate frame it sends a reset of all banks followed by a full mask and fresh data. Every case is followed by a sweep that reads all 512 offsets and compares them with a model of the page.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int OFF_W  = 9;
  localparam int BYTE_W = 8;
  localparam int NBANK  = 8;
  localparam int IDX_W  = 6;
  localparam int DEF_W  = 512;

  localparam int B_FONT = 0, B_ART = 1, B_EXT = 2, B_SGP = 3;
  localparam int B_APAL = 4, B_XPAL = 5, B_TIM = 6, B_ENH = 7;

  typedef struct packed {
    logic             hit;
    logic [2:0]       bank;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic dec_t decode_off(input logic [OFF_W-1:0] off);
    dec_t d;
    logic [OFF_W-1:0] rel;
    d = '0;
    rel = '0;
    if (off == 9'd3) begin
      d.hit = 1'b1; d.bank = 3'(B_FONT);
    end else if (off == 9'd4) begin
      d.hit = 1'b1; d.bank = 3'(B_ART);
    end else if (off == 9'd5) begin
      d.hit = 1'b1; d.bank = 3'(B_EXT);
    end else if (off == 9'd8) begin
      d.hit = 1'b1; d.bank = 3'(B_ENH);
    end else if (off >= 9'd32 && off <= 9'd53) begin
      d.hit = 1'b1; d.bank = 3'(B_SGP); rel = off - 9'd32;
    end else if (off >= 9'd64 && off <= 9'd127) begin
      d.hit = 1'b1; d.bank = 3'(B_APAL); rel = off - 9'd64;
    end else if (off >= 9'd128 && off <= 9'd135) begin
      d.hit = 1'b1; d.bank = 3'(B_XPAL); rel = off - 9'd128;
    end else if (off >= 9'd480 && off <= 9'd490 && off != 9'd485) begin
      d.hit = 1'b1; d.bank = 3'(B_TIM); rel = off - 9'd480;
    end
    d.idx = rel[IDX_W-1:0];
    return d;
  endfunction

  function automatic int bank_depth(input int b);
    case (b)
      B_SGP:   return 22;
      B_APAL:  return 64;
      B_XPAL:  return 8;
      B_TIM:   return 11;
      default: return 1;
    endcase
  endfunction

  function automatic logic [DEF_W-1:0] bank_default(input int b);
    logic [DEF_W-1:0] v;
    v = '0;
    case (b)
      B_ART: v[7:0] = 8'h0D;
      B_EXT: v[7:0] = 8'h40;
      B_TIM: v[87:0] = {8'h21, 8'h02, 8'h0A, 8'hE0, 8'h01, 8'h00,
                        8'h30, 8'h60, 8'h10, 8'h80, 8'h02};
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/ldr_decode.sv
module ldr_decode
  import ldr_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  output dec_t             dec
);
  always_comb dec = decode_off(offset);
endmodule

// File: rtl/ldr_bank.sv
module ldr_bank #(
  parameter int DEPTH = 1,
  parameter logic [511:0] DEF = '0,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DEF[i*8 +: 8];
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(ridx) < DEPTH) rdata = mem[ridx];
  end

  p_restore_r2: assert property (@(posedge clk) disable iff (rst)
    (clr && !we) |=> (mem[0] == DEF[7:0]));
  p_store_r4: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> (mem[$past(widx)] == $past(wdata)));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!we && !clr) |=> $stable(mem[0]));
endmodule

// File: rtl/page_loader_top.sv
module page_loader_top
  import ldr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             wr_valid,
  input  logic [OFF_W-1:0] wr_offset,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_offset,
  output logic [7:0]       rd_data
);
  dec_t             wdec, rdec;
  logic [NBANK-1:0] mask_q, mask_eff, restore;
  logic [NBANK-1:0] bank_we;
  logic [7:0]       bank_rd [NBANK];
  logic [7:0]       rd_next;
  logic             mask_wr;

  ldr_decode u_wdec (.offset(wr_offset), .dec(wdec));
  ldr_decode u_rdec (.offset(rd_offset), .dec(rdec));

  assign mask_wr  = wr_valid && (wr_offset == 9'd1);
  assign mask_eff = frame_start ? '0 : mask_q;
  assign restore  = (wr_valid && wr_offset == 9'd0) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst)              mask_q <= '0;
    else if (mask_wr)     mask_q <= wr_data;
    else if (frame_start) mask_q <= '0;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int D = bank_depth(b);
    localparam int W = (D > 1) ? $clog2(D) : 1;
    assign bank_we[b] = wr_valid && wdec.hit && (int'(wdec.bank) == b) && mask_eff[b];
    ldr_bank #(.DEPTH(D), .DEF(bank_default(b))) u_bank (
      .clk(clk), .rst(rst), .clr(restore[b]), .we(bank_we[b]),
      .widx(wdec.idx[W-1:0]), .wdata(wr_data),
      .ridx(rdec.idx[W-1:0]), .rdata(bank_rd[b]));
  end

  always_comb begin
    rd_next = '0;
    if (rdec.hit)              rd_next = bank_rd[rdec.bank];
    else if (rd_offset == 9'd1) rd_next = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  p_mask_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !mask_wr) |=> (mask_q == '0));
  p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(wr_data)));
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!rdec.hit && rd_offset != 9'd1) |=> (rd_data == 8'h00));
  p_one_writer_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_we) <= 1);
endmodule

// File: tb/page_loader_top_test.sv
module page_loader_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_offset = '0;
  logic [7:0] wr_data = '0;
  logic [8:0] rd_offset = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem_m [512];
  logic [7:0] mask_m;

  page_loader_top uut (.clk(clk), .rst(rst), .frame_start(frame_start),
    .wr_valid(wr_valid), .wr_offset(wr_offset), .wr_data(wr_data),
    .rd_offset(rd_offset), .rd_data(rd_data));

  always #4 clk = ~clk;

  function automatic int bank_of(input int off);
    if (off == 3) return 0;
    if (off == 4) return 1;
    if (off == 5) return 2;
    if (off == 8) return 7;
    if (off >= 32 && off <= 53) return 3;
    if (off >= 64 && off <= 127) return 4;
    if (off >= 128 && off <= 135) return 5;
    if (off >= 480 && off <= 490 && off != 485) return 6;
    return -1;
  endfunction

  function automatic logic [7:0] def_of(input int off);
    case (off)
      4: return 8'h0D;
      5: return 8'h40;
      480: return 8'h02; 481: return 8'h80; 482: return 8'h10;
      483: return 8'h60; 484: return 8'h30; 486: return 8'h01;
      487: return 8'hE0; 488: return 8'h0A; 489: return 8'h02;
      490: return 8'h21;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_of(input int off);
    if (off == 1) return mask_m;
    if (bank_of(off) < 0) return 8'h00;
    return mem_m[off];
  endfunction

  task automatic model_reset(input logic [7:0] v);
    for (int o = 0; o < 512; o++)
      if (bank_of(o) >= 0 && v[bank_of(o)]) mem_m[o] = def_of(o);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [7:0] d, input logic fs);
    @(negedge clk);
    wr_valid = 1'b1; wr_offset = 9'(off); wr_data = d; frame_start = fs;
    @(negedge clk);
    wr_valid = 1'b0; frame_start = 1'b0;
    if (fs) mask_m = 8'h00;
    if (off == 0) model_reset(d);
    else if (off == 1) mask_m = d;
    else if (bank_of(off) >= 0 && mask_m[bank_of(off)]) mem_m[off] = d;
  endtask

  task automatic new_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    mask_m = 8'h00;
  endtask

  task automatic sweep(input string tag);
    for (int o = 0; o < 512; o++) begin
      @(negedge clk);
      rd_offset = 9'(o);
      @(posedge clk); #1;
      if (o == 1) check("R3", rd_data, exp_of(o));
      else if (bank_of(o) < 0) check("R6", rd_data, exp_of(o));
      else check(tag, rd_data, exp_of(o));
    end
  endtask

  task automatic fill(input int mul, input int add);
    for (int o = 2; o < 512; o++) wr(o, 8'((o * mul + add) & 255), 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int o = 0; o < 512; o++) mem_m[o] = def_of(o);
    mask_m = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sweep("R1");

    new_frame(); wr(1, 8'hFF, 1'b0); fill(7, 3); sweep("R4");
    new_frame(); wr(1, 8'h55, 1'b0); fill(13, 91); sweep("R5");
    new_frame(); wr(1, 8'hAA, 1'b0); fill(5, 200); sweep("R5");

    new_frame(); wr(0, 8'h0F, 1'b0); sweep("R2");
    new_frame(); wr(1, 8'hFF, 1'b0); fill(3, 17);
    new_frame(); wr(0, 8'hF0, 1'b0); sweep("R2");

    new_frame(); wr(1, 8'hFF, 1'b0); fill(11, 5);
    new_frame(); wr(0, 8'hFF, 1'b0); wr(1, 8'hFF, 1'b0);
    for (int o = 3; o <= 8; o++) wr(o, 8'(o + 8'h90), 1'b0);
    for (int o = 480; o <= 490; o++) wr(o, 8'(o ^ 9'h0C3), 1'b0);
    sweep("R8");

    new_frame(); fill(9, 44); sweep("R7");
    wr(1, 8'hFF, 1'b0);
    wr(3, 8'h5A, 1'b1);
    @(negedge clk); rd_offset = 9'd3;
    @(posedge clk); #1; check("R7", rd_data, exp_of(3));
    @(negedge clk); rd_offset = 9'd1;
    @(posedge clk); #1; check("R7", rd_data, 8'h00);
    wr(1, 8'h3C, 1'b1);
    @(negedge clk); rd_offset = 9'd1;
    @(posedge clk); #1; check("R7", rd_data, 8'h3C);

    @(negedge clk); rd_offset = 9'd4;
    @(posedge clk); #1;
    @(negedge clk); rd_offset = 9'd5;
    #1; check("R9", rd_data, exp_of(4));
    @(posedge clk); #1; check("R9", rd_data, exp_of(5));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule